// File: doc/BRIEF.md
# Fractional BCD Stopwatch Timer

This block is a two-digit decimal stopwatch that runs from a binary 256 Hz tick enable. It shows hundredths and tenths of a second as BCD digits. A 256 Hz base does not divide evenly by 100, so the block spaces the hundredth steps 2 or 3 ticks apart. As a result, a tenth lasts either 25 or 26 ticks, and one full revolution of the tenths digit takes exactly 256 ticks, which is one second.

Software reads the packed count. A synchronous clear control zeroes the count, and a run input starts or freezes it. Each time the tenths digit wraps from 9 to 0, the block emits a one-cycle 1 Hz pulse and sets a sticky interrupt request. The request stays set until software acknowledges it.

Pacing is done by a three-state gap machine:
- `PH_FIRST`: no ticks have passed since the last step.
- `PH_SECOND`: one tick has passed.
- `PH_THIRD`: two ticks have passed.

The transitions are as follows:
- `PH_FIRST` goes to `PH_SECOND` on a counted tick.
- `PH_SECOND` goes to `PH_FIRST` and steps the hundredths digit when the current gap is short (2 ticks).
- `PH_SECOND` goes to `PH_THIRD` when the current gap is long (3 ticks).
- `PH_THIRD` goes to `PH_FIRST` and steps the hundredths digit.
- Clear forces `PH_FIRST` from any state.

Top module: `frac_stopwatch`

## Requirements
- R1: After `rst_n` is released, `count` is 0x00, `pulse_1hz` is 0 and `irq` is 0.
- R2: A cycle with `sw_reset` high clears both digits and the gap machine, whatever `run` and `tick` are, so the next hundredth step comes 3 counted ticks later.
- R3: `count[3:0]` holds the hundredths digit and `count[7:4]` holds the tenths digit. The gap (in ticks) that precedes the step from hundredths value h is 3 when h is even and 2 when h is odd, except for the case in R4.
- R4: In a long tenth, the gap before the step from hundredths value 5 is 3 ticks, which makes that tenth 26 ticks long.
- R5: A tenth is long (26 ticks) when bit 1 of the tenths digit is 0, which is the case for digits 0, 1, 4, 5, 8 and 9. Otherwise it is short (25 ticks).
- R6: Starting from zero, the count returns to 0x00 after exactly 256 counted ticks and not before.
- R7: `pulse_1hz` is high for exactly the one cycle after the tick that wraps the tenths digit from 9 to 0.
- R8: `irq` sets on that wrap and then holds until a cycle with `irq_ack` high. If a wrap and an acknowledge fall in the same cycle, the set wins.
- R9: While `run` is low, `tick` has no effect, and counting resumes from the exact held position.
- R10: Each digit stays within 0 to 9, and `count` changes only on a counted tick or on clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 256 Hz single-cycle enable |
| run | input | 1 | 1 counts ticks, 0 freezes |
| sw_reset | input | 1 | Synchronous clear of count and pacing |
| irq_ack | input | 1 | Clears the interrupt request |
| count | output | 8 | {tenths BCD, hundredths BCD} |
| pulse_1hz | output | 1 | One-cycle pulse on tenths wrap |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest cases are the ones only reachable after a long run of ticks. The lone 3-tick gap at hundredths value 5 appears only inside the six long tenths, and the wrap that coincides with an acknowledge needs exactly 255 counted ticks beforehand. The stimulus therefore drives full seconds tick by tick against a reference model. It also clears mid-gap and then issues 255 ticks before placing the acknowledge on the wrapping tick, and it inserts stopped ticks partway through a gap to show that the pacing state is held.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int DIGIT_W = 4;
    localparam int NDIG    = 2;
    localparam int DMAX    = 9;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_THIRD  = 2'd2
    } ph_e;

    // Long (3-tick) gap: even hundredth, or hundredth 5 inside a long tenth
    function automatic logic long_gap(input logic [DIGIT_W-1:0] hund,
                                      input logic [DIGIT_W-1:0] tenth);
        return (hund[0] == 1'b0) || (hund == 4'd5 && tenth[1] == 1'b0);
    endfunction
endpackage

// File: rtl/sw_gap_fsm.sv
module sw_gap_fsm
    import sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic is_long,
    output logic step
);
    ph_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_FIRST;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (clr) begin
            nxt = PH_FIRST;
        end else if (adv) begin
            unique case (state)
                PH_FIRST:  nxt = PH_SECOND;
                PH_SECOND: nxt = is_long ? PH_THIRD : PH_FIRST;
                PH_THIRD:  nxt = PH_FIRST;
                default:   nxt = PH_FIRST;
            endcase
        end
    end

    always_comb begin
        step = 1'b0;
        if (!clr && adv) begin
            unique case (state)
                PH_FIRST:  step = 1'b0;
                PH_SECOND: step = !is_long;
                PH_THIRD:  step = 1'b1;
                default:   step = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit #(
    parameter int W    = 4,
    parameter int MAXV = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         carry
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    assign carry = inc && (value == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= '0;
        else if (clr)    value <= '0;
        else if (carry)  value <= '0;
        else if (inc)    value <= value + 1'b1;
    end
endmodule

// File: rtl/frac_stopwatch.sv
module frac_stopwatch
    import sw_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    run,
    input  logic                    sw_reset,
    input  logic                    irq_ack,
    output logic [NDIG*DIGIT_W-1:0] count,
    output logic                    pulse_1hz,
    output logic                    irq
);
    logic [NDIG:0]        chain;
    logic [DIGIT_W-1:0]   digit [NDIG];
    logic                 adv, is_long;

    assign adv     = tick && run;
    assign is_long = long_gap(digit[0], digit[1]);

    sw_gap_fsm u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sw_reset),
        .adv     (adv),
        .is_long (is_long),
        .step    (chain[0])
    );

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        sw_bcd_digit #(.W(DIGIT_W), .MAXV(DMAX)) u_dig (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (sw_reset),
            .inc   (chain[g]),
            .value (digit[g]),
            .carry (chain[g+1])
        );
        assign count[g*DIGIT_W +: DIGIT_W] = digit[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_1hz <= 1'b0;
            irq       <= 1'b0;
        end else begin
            pulse_1hz <= chain[NDIG];
            irq       <= chain[NDIG] || (irq && !irq_ack);
        end
    end
endmodule

// File: rtl/sw_chk.sv
module sw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       run,
    input logic       sw_reset,
    input logic       irq_ack,
    input logic [7:0] count,
    input logic       pulse_1hz,
    input logic       irq
);
    // R10
    digits_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count[3:0] <= 4'd9 && count[7:4] <= 4'd9);
    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && run) && !sw_reset) |=> $stable(count));
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (count == 8'h00 && !pulse_1hz));
    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_1hz |=> !pulse_1hz);
    // R7
    pulse_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_1hz |-> count == 8'h00);
    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_1hz |-> irq);
    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
endmodule

bind frac_stopwatch sw_chk u_sw_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .sw_reset(sw_reset),
    .irq_ack(irq_ack), .count(count), .pulse_1hz(pulse_1hz), .irq(irq)
);

// File: tb/tb_frac_stopwatch.sv
module tb_frac_stopwatch;
    logic clk = 0, rst_n = 0, tick = 0, run = 0, sw_reset = 0, irq_ack = 0;
    logic [7:0] count;
    logic pulse_1hz, irq;
    int checks = 0, errors = 0, pulses = 0;
    bit done = 0;

    typedef struct packed { logic [7:0] cnt; logic pls; logic irq; } exp_t;
    exp_t q[$];
    int mph = 0, mh = 0, mt = 0;
    logic mirq = 0;

    always #4 clk = ~clk;

    frac_stopwatch dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // gap before stepping from hundredth h inside tenth t (R3 R4 R5)
    function automatic int gap_of(input int h, input int t);
        bit long_tenth = (t == 0 || t == 1 || t == 4 || t == 5 || t == 8 || t == 9);
        if (h % 2 == 0) return 3;
        if (h == 5 && long_tenth) return 3;
        return 2;
    endfunction

    // driver: one tick cycle, expected result pushed to scoreboard
    task automatic step(input logic r, input logic a, input logic c);
        exp_t e;
        bit wrap = 0;
        @(negedge clk);
        run = r; irq_ack = a; sw_reset = c; tick = 1;
        if (c) begin
            mph = 0; mh = 0; mt = 0;
        end else if (r) begin
            mph++;
            if (mph == gap_of(mh, mt)) begin
                mph = 0;
                if (mh == 9) begin
                    mh = 0;
                    if (mt == 9) begin mt = 0; wrap = 1; end else mt++;
                end else mh++;
            end
        end
        mirq = wrap || (mirq && !a);
        e.cnt = {4'(mt), 4'(mh)}; e.pls = wrap; e.irq = mirq;
        q.push_back(e);
        @(negedge clk);
        tick = 0; irq_ack = 0; sw_reset = 0;
    endtask

    // monitor
    always @(posedge clk) begin
        if (tick) begin
            exp_t e;
            #2;
            if (q.size() == 0) begin
                chk(0, "R6 scoreboard empty", 0, 1);
            end else begin
                e = q.pop_front();
                chk(count == e.cnt, "R3 R4 R5 R6 R9 R2 count", count, e.cnt);
                chk(pulse_1hz == e.pls, "R7 pulse", pulse_1hz, e.pls);
                chk(irq == e.irq, "R8 irq", irq, e.irq);
                if (pulse_1hz) pulses++;
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(count == 8'h00 && !pulse_1hz && !irq, "R1 reset", {count, pulse_1hz, irq}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(count == 8'h00 && !irq, "R1 after release", {count, irq}, 0);

        // full second, checked tick by tick
        for (int i = 0; i < 255; i++) step(1, 0, 0);
        chk(count == 8'h99, "R6 before wrap", count, 8'h99);
        step(1, 0, 0);
        chk(count == 8'h00, "R6 256 ticks", count, 0);
        chk(pulses == 1, "R6 one pulse", pulses, 1);
        @(negedge clk);
        chk(!pulse_1hz, "R7 pulse one cycle", pulse_1hz, 0);

        repeat (5) @(negedge clk);
        chk(irq, "R8 sticky", irq, 1);
        irq_ack = 1; @(negedge clk); irq_ack = 0; mirq = 0;
        chk(!irq, "R8 ack clears", irq, 0);

        // stop mid-gap (R9)
        for (int i = 0; i < 37; i++) step(1, 0, 0);
        for (int i = 0; i < 10; i++) step(0, 0, 0);
        for (int i = 0; i < 40; i++) step(1, 0, 0);

        // clear mid-gap with run high (R2)
        step(1, 0, 0);
        step(1, 0, 1);
        chk(count == 8'h00, "R2 clear", count, 0);
        step(1, 0, 0); step(1, 0, 0);
        chk(count == 8'h00, "R2 no step at 2", count, 0);
        step(1, 0, 0);
        chk(count == 8'h01, "R2 step at 3", count, 1);

        // wrap with simultaneous ack (R8 set wins)
        for (int i = 0; i < 252; i++) step(1, 0, 0);
        step(1, 1, 0);
        chk(irq && count == 8'h00, "R8 set wins", {count, irq}, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule